// File: doc/BRIEF.md
# Nine-byte to 9-bit word packer

This block fills a memory that is nine bits wide with byte data so that every ninth bit carries payload. Bytes arrive on a valid/ready stream in groups of nine, called A through I in arrival order, and the first byte of each group travels with a group index. Once the ninth byte of a group has been taken in, the block writes eight 9-bit words on eight consecutive clocks, with a write strobe and a word address for each. The bits of the nine bytes are scattered over those eight words in a fixed arrangement that a read-side unpacker can undo.

Bytes A to H of group g occupy byte addresses 8g to 8g+7 of the byte space a reader sees. Byte I occupies an overflow region placed after all packed bytes, at address NUM_BLOCKS*1024 + g. The block computes that address for the current group on a helper output. With NUM_BLOCKS memory blocks of 1024 words, the memory stores 1152*NUM_BLOCKS bytes, compared with 1024*NUM_BLOCKS bytes when each byte takes a whole word. A group whose index is NUM_BLOCKS*128 or larger does not fit in the memory, so it is rejected without any writes.

Top module: `ninebyte_packer`

## Requirements
- R1: While rst_n is low, and on the first clock after it is released, in_ready is 1 and wr_en, done and err are 0. A group that was partly received or partly written when reset arrived is dropped, and the next accepted byte is taken as byte A.
- R2: A byte is accepted on a clock edge where in_valid and in_ready are both 1. Accepted bytes are labelled A, B, C, D, E, F, G, H, I in that order. in_group is sampled only together with byte A, and its value during the other eight bytes has no effect.
- R3: in_ready is 0 from the clock after byte I is accepted until the clock after word 7 is written, and is 1 again on the clock that follows word 7.
- R4: The eight words of an accepted group come out on eight consecutive clocks with wr_en high, starting on the clock after byte I is accepted, in ascending order k = 0..7, at wr_addr = group*8 + k.
- R5: Word 0 is {I[3:0], A[4:0]} and word 1 is {I[7:4], B[4:0]}, with the most significant bit on the left.
- R6: Word 2 is {F[7:6], E[7:6], C[4:0]} and word 3 is {H[7:6], G[7:6], D[4:0]}.
- R7: Word 4 is {A[7:5], E[5:0]}, word 5 is {B[7:5], F[5:0]}, word 6 is {C[7:5], G[5:0]} and word 7 is {D[7:5], H[5:0]}.
- R8: done is 1 for exactly one clock per written group, the clock on which word 7 is written (wr_addr low three bits equal 7), and is 0 at all other times.
- R9: A group whose index is NUM_BLOCKS*128 or larger is rejected: err is 1 for the one clock after byte I is accepted, in_ready is 0 on that clock and 1 on the next, and wr_en stays 0.
- R10: ninth_addr equals NUM_BLOCKS*1024 plus the group index captured with the most recent byte A. It holds that value while the words of the group are written.
- R11: While in_valid is 0, no byte is accepted, however long the gap lasts and at whatever position in the group it falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| in_valid | input | 1 | A byte is offered |
| in_ready | output | 1 | The block can take a byte |
| in_byte | input | 8 | Byte data |
| in_group | input | GIDX_W ($clog2(NUM_BLOCKS*128), 10 by default) | Group index, sampled with byte A |
| wr_en | output | 1 | Word write strobe |
| wr_addr | output | WADDR_W (GIDX_W+3, 13 by default) | Word address, group*8 + k |
| wr_data | output | 9 | Packed word |
| done | output | 1 | Last word of a group is being written |
| err | output | 1 | Group index out of range, group dropped |
| ninth_addr | output | BADDR_W ($clog2(NUM_BLOCKS*1152), 13 by default) | Byte address of byte I of the current group |

## Verification
The hardest case to reach from the ports is the rejection path. When NUM_BLOCKS is a power of two, every value of in_group is in range, so no rejection can happen. The bench therefore builds the block with three memory blocks, which allows 384 valid groups in a 9-bit index. It sends every index from 0 to 511, so that all valid groups are written and all out-of-range groups are rejected. It also drops the reset in the middle of collection and in the middle of writing, and leaves in_valid low for gaps inside groups, so that it can show that the byte order restarts and that gaps are not read as bytes.

// File: rtl/nbpack_pkg.sv
package nbpack_pkg;

  localparam int BYTE_W           = 8;
  localparam int WORD_W           = 9;
  localparam int GROUP_BYTES      = 9;
  localparam int GROUP_WORDS      = 8;
  localparam int WORD_SEL_W       = $clog2(GROUP_WORDS);
  localparam int SLOT_W           = $clog2(GROUP_BYTES + 1);
  localparam int GROUP_BITS       = GROUP_BYTES * BYTE_W;
  localparam int BLOCK_WORDS      = 1024;
  localparam int GROUPS_PER_BLOCK = BLOCK_WORDS / GROUP_WORDS;
  localparam int BYTES_PER_BLOCK  = GROUPS_PER_BLOCK * GROUP_BYTES;

  typedef logic [BYTE_W-1:0]     byte_t;
  typedef logic [WORD_W-1:0]     word_t;
  typedef logic [GROUP_BITS-1:0] group_bytes_t;

  typedef enum logic [1:0] {
    SEQ_COLLECT = 2'd0,
    SEQ_EMIT    = 2'd1,
    SEQ_REJECT  = 2'd2
  } seq_state_e;

  // Slot 0 holds the first byte of a group (A) and slot 8 the last (I).
  function automatic byte_t slot_of(input group_bytes_t grp, input int idx);
    return grp[idx*BYTE_W +: BYTE_W];
  endfunction

  // Word k of a group: words 0..3 keep bits 4:0 of bytes A..D, and words
  // 4..7 keep bits 5:0 of bytes E..H. The upper bits of both halves are
  // spread over the spare tops of the other words.
  function automatic word_t build_word(input group_bytes_t grp, input int k);
    byte_t a_b, b_b, w_lo, w_hi;
    word_t w;
    if (k < GROUP_WORDS / 2) begin
      w_lo = slot_of(grp, k);
      case (k)
        0: begin
          a_b = slot_of(grp, 8);
          w   = {a_b[3:0], w_lo[4:0]};
        end
        1: begin
          a_b = slot_of(grp, 8);
          w   = {a_b[7:4], w_lo[4:0]};
        end
        2: begin
          a_b = slot_of(grp, 5);
          b_b = slot_of(grp, 4);
          w   = {a_b[7:6], b_b[7:6], w_lo[4:0]};
        end
        default: begin
          a_b = slot_of(grp, 7);
          b_b = slot_of(grp, 6);
          w   = {a_b[7:6], b_b[7:6], w_lo[4:0]};
        end
      endcase
    end else begin
      w_hi = slot_of(grp, k - GROUP_WORDS / 2);
      w_lo = slot_of(grp, k);
      w    = {w_hi[7:5], w_lo[5:0]};
    end
    return w;
  endfunction

endpackage

// File: rtl/nbpack_collect.sv
module nbpack_collect
  import nbpack_pkg::*;
#(
  parameter int GIDX_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic               ready_i,
  input  byte_t              in_byte,
  input  logic [GIDX_W-1:0]  in_group,
  output group_bytes_t       grp_o,
  output logic [GIDX_W-1:0]  group_o,
  output logic               last_o
);

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(GROUP_BYTES - 1);

  logic              accept;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [GIDX_W-1:0] group_q;
  logic              group_en;

  assign accept   = in_valid && ready_i;
  assign last_o   = accept && (slot_q == LAST_SLOT);
  assign group_en = accept && (slot_q == '0);

  always_comb begin
    slot_d = slot_q;
    if (accept) begin
      if (slot_q == LAST_SLOT) slot_d = '0;
      else                     slot_d = slot_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= '0;
    else        slot_q <= slot_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        group_q <= '0;
    else if (group_en) group_q <= in_group;
  end

  for (genvar s = 0; s < GROUP_BYTES; s++) begin : g_slot
    logic  en;
    byte_t data_q;
    assign en = accept && (slot_q == SLOT_W'(s));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  data_q <= '0;
      else if (en) data_q <= in_byte;
    end
    assign grp_o[s*BYTE_W +: BYTE_W] = data_q;
  end

  assign group_o = group_q;

  // R2: the slot count never leaves the nine positions of a group
  a_r2_slot_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q <= LAST_SLOT);

  // R11: with no byte offered the slot position holds
  a_r11_gap_holds_slot: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(slot_q));

endmodule

// File: rtl/nbpack_seq.sv
module nbpack_seq
  import nbpack_pkg::*;
#(
  parameter int GIDX_W = 10,
  parameter int GROUPS = 896
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  last_i,
  input  logic [GIDX_W-1:0]     group_i,
  output logic                  ready_o,
  output logic                  wr_en_o,
  output logic [WORD_SEL_W-1:0] k_o,
  output logic                  done_o,
  output logic                  err_o
);

  localparam logic [GIDX_W:0]         GROUP_LIMIT = (GIDX_W+1)'(GROUPS);
  localparam logic [WORD_SEL_W-1:0]   LAST_K      = WORD_SEL_W'(GROUP_WORDS - 1);

  seq_state_e            state_q, state_d;
  logic [WORD_SEL_W-1:0] k_q, k_d;
  logic                  group_ok;

  assign group_ok = ({1'b0, group_i} < GROUP_LIMIT);

  always_comb begin
    state_d = state_q;
    k_d     = k_q;
    case (state_q)
      SEQ_COLLECT: begin
        k_d = '0;
        if (last_i) state_d = group_ok ? SEQ_EMIT : SEQ_REJECT;
      end
      SEQ_EMIT: begin
        k_d = k_q + 1'b1;
        if (k_q == LAST_K) state_d = SEQ_COLLECT;
      end
      SEQ_REJECT: state_d = SEQ_COLLECT;
      default:    state_d = SEQ_COLLECT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_COLLECT;
      k_q     <= '0;
    end else begin
      state_q <= state_d;
      k_q     <= k_d;
    end
  end

  assign ready_o = (state_q == SEQ_COLLECT);
  assign wr_en_o = (state_q == SEQ_EMIT);
  assign k_o     = k_q;
  assign done_o  = wr_en_o && (k_q == LAST_K);
  assign err_o   = (state_q == SEQ_REJECT);

  // R3: intake stops on the clock after the last byte of a group
  a_r3_busy_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    last_i |=> !ready_o);

  // R9: an out-of-range group raises err and writes nothing
  a_r9_reject_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (last_i && !group_ok) |=> (err_o && !wr_en_o));

  // R8: after the last word the block is idle and ready again
  a_r8_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (ready_o && !wr_en_o && !done_o));

  // R4: words advance one index per clock without gaps
  a_r4_k_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && !done_o) |=> (wr_en_o && k_o == $past(k_o) + 1'b1));

endmodule

// File: rtl/nbpack_mapper.sv
module nbpack_mapper
  import nbpack_pkg::*;
(
  input  group_bytes_t          grp_i,
  input  logic [WORD_SEL_W-1:0] k_i,
  output word_t                 word_o
);

  word_t cand [GROUP_WORDS];

  for (genvar j = 0; j < GROUP_WORDS; j++) begin : g_word
    assign cand[j] = build_word(grp_i, j);
  end

  assign word_o = cand[k_i];

endmodule

// File: rtl/nbpack_ninth_addr.sv
module nbpack_ninth_addr
  import nbpack_pkg::*;
#(
  parameter int NUM_BLOCKS = 7,
  parameter int GIDX_W     = 10,
  parameter int BADDR_W    = 13
) (
  input  logic [GIDX_W-1:0]  group_i,
  output logic [BADDR_W-1:0] addr_o
);

  localparam logic [BADDR_W-1:0] OVF_BASE = BADDR_W'(NUM_BLOCKS * BLOCK_WORDS);

  assign addr_o = OVF_BASE + BADDR_W'(group_i);

endmodule

// File: rtl/ninebyte_packer.sv
module ninebyte_packer
  import nbpack_pkg::*;
#(
  parameter  int NUM_BLOCKS = 7,
  localparam int GIDX_W     = $clog2(NUM_BLOCKS * GROUPS_PER_BLOCK),
  localparam int WADDR_W    = GIDX_W + WORD_SEL_W,
  localparam int BADDR_W    = $clog2(NUM_BLOCKS * BYTES_PER_BLOCK)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [7:0]         in_byte,
  input  logic [GIDX_W-1:0]  in_group,
  output logic               wr_en,
  output logic [WADDR_W-1:0] wr_addr,
  output logic [8:0]         wr_data,
  output logic               done,
  output logic               err,
  output logic [BADDR_W-1:0] ninth_addr
);

  localparam int GROUPS = NUM_BLOCKS * GROUPS_PER_BLOCK;

  group_bytes_t          grp;
  logic [GIDX_W-1:0]     group_q;
  logic                  last;
  logic [WORD_SEL_W-1:0] k;

  nbpack_collect #(.GIDX_W(GIDX_W)) u_collect (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .ready_i  (in_ready),
    .in_byte  (in_byte),
    .in_group (in_group),
    .grp_o    (grp),
    .group_o  (group_q),
    .last_o   (last)
  );

  nbpack_seq #(.GIDX_W(GIDX_W), .GROUPS(GROUPS)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .last_i  (last),
    .group_i (group_q),
    .ready_o (in_ready),
    .wr_en_o (wr_en),
    .k_o     (k),
    .done_o  (done),
    .err_o   (err)
  );

  nbpack_mapper u_mapper (
    .grp_i  (grp),
    .k_i    (k),
    .word_o (wr_data)
  );

  nbpack_ninth_addr #(
    .NUM_BLOCKS (NUM_BLOCKS),
    .GIDX_W     (GIDX_W),
    .BADDR_W    (BADDR_W)
  ) u_ninth (
    .group_i (group_q),
    .addr_o  (ninth_addr)
  );

  assign wr_addr = {group_q, k};

  // R8: done only accompanies the write of word 7
  a_r8_done_on_last_word: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (wr_en && wr_addr[WORD_SEL_W-1:0] == '1));

  // R4: consecutive writes of a group go to consecutive addresses
  a_r4_addr_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !done) |=> (wr_en && wr_addr == $past(wr_addr) + 1'b1));

  // R9: err and a write never share a clock, and err lasts one clock
  a_r9_err_single: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!wr_en && !in_ready) ##1 (!err && in_ready));

  // R10: the overflow address holds while a group is written
  a_r10_ninth_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !done) |=> $stable(ninth_addr));

endmodule

// File: tb/ninebyte_packer_test.sv
module ninebyte_packer_test;

  localparam int NB      = 3;
  localparam int GROUPS  = NB * 128;
  localparam int GIDX_W  = $clog2(NB * 128);
  localparam int WADDR_W = GIDX_W + 3;
  localparam int BADDR_W = $clog2(NB * 1152);

  logic               clk = 1'b0;
  logic               rst_n;
  logic               in_valid;
  logic               in_ready;
  logic [7:0]         in_byte;
  logic [GIDX_W-1:0]  in_group;
  logic               wr_en;
  logic [WADDR_W-1:0] wr_addr;
  logic [8:0]         wr_data;
  logic               done;
  logic               err;
  logic [BADDR_W-1:0] ninth_addr;

  ninebyte_packer #(.NUM_BLOCKS(NB)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_byte    (in_byte),
    .in_group   (in_group),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .done       (done),
    .err        (err),
    .ninth_addr (ninth_addr)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  logic [7:0] tx [9];
  logic [8:0] rx [8];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [8:0] expect_word(input int k);
    case (k)
      0: return {tx[8][3:0], tx[0][4:0]};
      1: return {tx[8][7:4], tx[1][4:0]};
      2: return {tx[5][7:6], tx[4][7:6], tx[2][4:0]};
      3: return {tx[7][7:6], tx[6][7:6], tx[3][4:0]};
      default: return {tx[k-4][7:5], tx[k][5:0]};
    endcase
  endfunction

  // Offer bytes tx[0..n-1]; the group index rides only with the first byte.
  task automatic send_bytes(input int g, input int n, input bit stall);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (stall && (i == 3 || i == 8)) begin
        in_valid = 1'b0;
        in_byte  = 8'hA5;
        in_group = GIDX_W'(g + 1);
        repeat (3) @(negedge clk);
      end
      in_valid = 1'b1;
      in_byte  = tx[i];
      in_group = (i == 0) ? GIDX_W'(g) : ~GIDX_W'(g);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_valid(input int g, input bit stall);
    logic [7:0] got [9];
    send_bytes(g, 9, stall);
    chk(ninth_addr == BADDR_W'(NB * 1024 + g), "R10 ninth_addr", ninth_addr, NB * 1024 + g);
    for (int k = 0; k < 8; k++) begin
      chk(wr_en === 1'b1, "R4 wr_en", wr_en, 1);
      chk(wr_addr == WADDR_W'(g * 8 + k), "R4 wr_addr", wr_addr, g * 8 + k);
      chk(done === (k == 7), "R8 done", done, (k == 7));
      chk(in_ready === 1'b0, "R3 in_ready busy", in_ready, 0);
      rx[k] = wr_data;
      if (k < 2)      chk(wr_data == expect_word(k), "R5 word", wr_data, expect_word(k));
      else if (k < 4) chk(wr_data == expect_word(k), "R6 word", wr_data, expect_word(k));
      else            chk(wr_data == expect_word(k), "R7 word", wr_data, expect_word(k));
      @(negedge clk);
    end
    chk(wr_en === 1'b0 && done === 1'b0, "R8 idle after group", {wr_en, done}, 0);
    chk(in_ready === 1'b1, "R3 in_ready back", in_ready, 1);
    got[0] = {rx[4][8:6], rx[0][4:0]};
    got[1] = {rx[5][8:6], rx[1][4:0]};
    got[2] = {rx[6][8:6], rx[2][4:0]};
    got[3] = {rx[7][8:6], rx[3][4:0]};
    got[4] = {rx[2][6:5], rx[4][5:0]};
    got[5] = {rx[2][8:7], rx[5][5:0]};
    got[6] = {rx[3][6:5], rx[6][5:0]};
    got[7] = {rx[3][8:7], rx[7][5:0]};
    got[8] = {rx[1][8:5], rx[0][8:5]};
    for (int i = 0; i < 9; i++)
      chk(got[i] == tx[i], stall ? "R11 byte after gap" : "R2 byte order", got[i], tx[i]);
  endtask

  task automatic run_reject(input int g);
    send_bytes(g, 9, 1'b0);
    chk(err === 1'b1 && wr_en === 1'b0 && in_ready === 1'b0, "R9 reject cycle",
        {err, wr_en, in_ready}, 3'b100);
    @(negedge clk);
    chk(err === 1'b0 && wr_en === 1'b0 && in_ready === 1'b1 && done === 1'b0,
        "R9 after reject", {err, wr_en, in_ready, done}, 4'b0010);
  endtask

  task automatic check_reset_state(input string tag);
    chk(in_ready === 1'b1 && wr_en === 1'b0 && done === 1'b0 && err === 1'b0, tag,
        {in_ready, wr_en, done, err}, 4'b1000);
  endtask

  task automatic fill_pattern(input int g, input int seed);
    for (int i = 0; i < 9; i++) tx[i] = 8'((g * 37 + i * 91 + seed * 29) ^ (g >> 3));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_byte  = '0;
    in_group = '0;
    repeat (3) @(negedge clk);
    check_reset_state("R1 during reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_reset_state("R1 after reset");

    // every in-range group, with gaps on some
    for (int g = 0; g < GROUPS; g++) begin
      fill_pattern(g, 1);
      run_valid(g, (g % 7) == 3);
    end

    // edge-value bytes on the first and last groups
    for (int i = 0; i < 9; i++) tx[i] = 8'hFF;
    run_valid(GROUPS - 1, 1'b0);
    for (int i = 0; i < 9; i++) tx[i] = 8'h00;
    run_valid(0, 1'b0);
    for (int b = 0; b < 8; b++) begin
      for (int i = 0; i < 9; i++) tx[i] = 8'(1 << ((b + i) % 8));
      run_valid(5 + b, 1'b1);
    end

    // every out-of-range index
    for (int g = GROUPS; g < (1 << GIDX_W); g++) begin
      fill_pattern(g, 2);
      run_reject(g);
    end
    fill_pattern(12, 3);
    run_valid(12, 1'b0);

    // reset in the middle of collection
    fill_pattern(40, 4);
    send_bytes(40, 5, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    check_reset_state("R1 reset mid collect");
    rst_n = 1'b1;
    @(negedge clk);
    fill_pattern(41, 5);
    run_valid(41, 1'b0);

    // reset in the middle of writing
    fill_pattern(77, 6);
    send_bytes(77, 9, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check_reset_state("R1 reset mid write");
    rst_n = 1'b1;
    @(negedge clk);
    check_reset_state("R1 after reset mid write");
    fill_pattern(78, 7);
    run_valid(78, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule